// File: doc/BRIEF.md
# Pin I/O Register Bank

This block is the software-visible register file of one general-purpose pin group. A processor reaches it over a simple word-addressed bus with an address, a write strobe, write data and read data. Through this bus the processor sets which pins it drives and the values they carry. It also reads both the unfiltered and the filtered state of the pins, and it programs the pin-change interrupt logic that sits next to the bank.

The bank drives a value and an enable for each pin. A pin whose enable is clear is left undriven and works as an input. The bank exports the interrupt enable, the source select, the trigger mode and the per-pin watch mask to the interrupt logic, and it takes back a one-cycle pulse when that logic detects an event. That pulse sets a pending flag, which software clears by writing a one. The input filter and the edge detector are separate blocks.

Writes take effect at the clock edge that samples the strobe. Read data is combinational from the current address.

Top module: `pin_bank_regs`

## Requirements
- R1: After reset, the pin values, pin enables, control fields, pending flag and watch mask are all 0.
- R2: A write to word offset 0x00 changes only the pin-value bits whose enable bit (offset 0x0C) is 1. All other pin-value bits keep their value. Offset 0x00 reads back the stored pin values.
- R3: Offset 0x0C holds the per-pin enables and reads them back. `pin_oe_o` follows it, and a pin with enable 0 is not driven.
- R4: Offset 0x10 holds the control word. Bit 31 is the interrupt enable, bit 3 the source select (0 = unfiltered, 1 = filtered), and bits 1:0 the trigger mode. All other bits read 0 and ignore writes.
- R5: Offset 0x14 bit 31 is the pending flag. A set pulse makes it 1 on the next edge. Writing 1 to bit 31 clears it, and writing 0 leaves it unchanged. All other bits read 0.
- R6: When a set pulse and a write-1-clear arrive in the same cycle, the flag is 1 afterwards.
- R7: Offset 0x04 reads the unfiltered pins and offset 0x08 the filtered pins, with bit i being pin i and the bits above the pin count reading 0. Writes to either offset change no register.
- R8: Offset 0x18 holds the per-pin watch mask with the same bit-to-pin mapping. It reads back and drives `irq_mask_o`.
- R9: An offset of 0x1C, or an address whose two low bits are not 00, reads 0, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| addr_i | input | 5 | Byte address within the bank |
| wen_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_raw_i | input | PIN_W | Unfiltered pin levels |
| pin_deb_i | input | PIN_W | Filtered pin levels |
| pin_out_o | output | PIN_W | Value driven on each pin |
| pin_oe_o | output | PIN_W | Drive enable for each pin |
| irq_en_o | output | 1 | Interrupt enable |
| irq_src_deb_o | output | 1 | Interrupt source: 1 = filtered |
| irq_mode_o | output | 2 | Trigger mode |
| irq_mask_o | output | PIN_W | Per-pin watch mask |
| irq_set_i | input | 1 | One-cycle event pulse from the interrupt logic |
| irq_pend_o | output | 1 | Pending flag |

## Verification
The assertions assume that the address, strobe, data and set pulse are stable around each rising edge and are known after reset. They also assume that at most one register is addressed per cycle, which holds because the decoder is fed by a single address. The bench changes every input one nanosecond after the edge and holds it for a full cycle. It mixes directed writes with random addresses, including misaligned and unmapped ones, random set pulses and changing pin levels. A behavioural model follows the same inputs and is compared with the outputs and the read data on every falling edge.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int NREG     = 7;
    localparam int EN_BIT   = 31;
    localparam int SRC_BIT  = 3;
    localparam int PEND_BIT = 31;

    typedef enum logic [2:0] {
        IDX_OUT  = 3'd0,
        IDX_RAW  = 3'd1,
        IDX_DEB  = 3'd2,
        IDX_OE   = 3'd3,
        IDX_CTL  = 3'd4,
        IDX_STAT = 3'd5,
        IDX_MASK = 3'd6,
        IDX_NONE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic       en;
        logic       src_deb;
        logic [1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
    import pin_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    output reg_idx_e          idx_o,
    output logic              hit_o,
    output logic [NREG-1:0]   wr_stb_o
);
    always_comb begin
        idx_o = reg_idx_e'(addr_i[ADDR_W-1:2]);
        hit_o = (addr_i[1:0] == 2'b00) && (idx_o != IDX_NONE);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_stb
        assign wr_stb_o[g] = wen_i && hit_o && (idx_o == reg_idx_e'(g));
    end
endmodule

// File: rtl/pin_bank_outregs.sv
module pin_bank_outregs #(
    parameter int PIN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_out_i,
    input  logic             wr_oe_i,
    input  logic [PIN_W-1:0] wdata_i,
    output logic [PIN_W-1:0] out_o,
    output logic [PIN_W-1:0] oe_o
);
    typedef struct packed {
        logic [PIN_W-1:0] out;
        logic [PIN_W-1:0] oe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_out_i) st_d.out = (st_q.out & ~st_q.oe) | (wdata_i & st_q.oe);
        if (wr_oe_i)  st_d.oe  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_o = st_q.out;
    assign oe_o  = st_q.oe;

    // R2
    out_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_out_i |=> (((st_q.out ^ $past(st_q.out)) & ~$past(st_q.oe)) == '0));
    // R2
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_out_i |=> $stable(st_q.out));
    // R3
    oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_oe_i |=> $stable(st_q.oe));
endmodule

// File: rtl/pin_bank_ctlstat.sv
module pin_bank_ctlstat
    import pin_bank_pkg::*;
#(
    parameter int PIN_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ctl_i,
    input  logic              wr_stat_i,
    input  logic              wr_mask_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              set_i,
    output ctrl_t             ctrl_o,
    output logic              pend_o,
    output logic [PIN_W-1:0]  mask_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic             pend;
        logic [PIN_W-1:0] mask;
    } st_t;

    st_t  st_d, st_q;
    logic clr_req;
    logic unused_wdata;

    assign clr_req      = wr_stat_i && wdata_i[PEND_BIT];
    assign unused_wdata = ^{wdata_i[EN_BIT-1:SRC_BIT+1], wdata_i[2]};

    always_comb begin
        st_d = st_q;
        if (wr_ctl_i) begin
            st_d.ctrl.en      = wdata_i[EN_BIT];
            st_d.ctrl.src_deb = wdata_i[SRC_BIT];
            st_d.ctrl.mode    = wdata_i[1:0];
        end
        if (wr_mask_i) st_d.mask = wdata_i[PIN_W-1:0];
        st_d.pend = set_i || (st_q.pend && !clr_req);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;

    // R5
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> pend_o);
    // R5
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat_i && wdata_i[PEND_BIT] && !set_i) |=> !pend_o);
    // R5
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !(wr_stat_i && wdata_i[PEND_BIT])) |=> $stable(pend_o));
    // R4
    ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_ctl_i |=> $stable(ctrl_o));
    // R8
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_mask_i |=> $stable(mask_o));
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int PIN_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [PIN_W-1:0]  pin_raw_i,
    input  logic [PIN_W-1:0]  pin_deb_i,
    output logic [PIN_W-1:0]  pin_out_o,
    output logic [PIN_W-1:0]  pin_oe_o,
    output logic              irq_en_o,
    output logic              irq_src_deb_o,
    output logic [1:0]        irq_mode_o,
    output logic [PIN_W-1:0]  irq_mask_o,
    input  logic              irq_set_i,
    output logic              irq_pend_o
);
    reg_idx_e        idx;
    logic            hit;
    logic [NREG-1:0] wr_stb;
    ctrl_t           ctrl;
    logic            unused_ro;

    assign unused_ro = wr_stb[IDX_RAW] | wr_stb[IDX_DEB];

    pin_bank_decode i_decode (
        .addr_i   (addr_i),
        .wen_i    (wen_i),
        .idx_o    (idx),
        .hit_o    (hit),
        .wr_stb_o (wr_stb)
    );

    pin_bank_outregs #(.PIN_W(PIN_W)) i_outregs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_out_i (wr_stb[IDX_OUT]),
        .wr_oe_i  (wr_stb[IDX_OE]),
        .wdata_i  (wdata_i[PIN_W-1:0]),
        .out_o    (pin_out_o),
        .oe_o     (pin_oe_o)
    );

    pin_bank_ctlstat #(.PIN_W(PIN_W)) i_ctlstat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_ctl_i  (wr_stb[IDX_CTL]),
        .wr_stat_i (wr_stb[IDX_STAT]),
        .wr_mask_i (wr_stb[IDX_MASK]),
        .wdata_i   (wdata_i),
        .set_i     (irq_set_i),
        .ctrl_o    (ctrl),
        .pend_o    (irq_pend_o),
        .mask_o    (irq_mask_o)
    );

    assign irq_en_o      = ctrl.en;
    assign irq_src_deb_o = ctrl.src_deb;
    assign irq_mode_o    = ctrl.mode;

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            unique case (idx)
                IDX_OUT:  rdata_o[PIN_W-1:0] = pin_out_o;
                IDX_RAW:  rdata_o[PIN_W-1:0] = pin_raw_i;
                IDX_DEB:  rdata_o[PIN_W-1:0] = pin_deb_i;
                IDX_OE:   rdata_o[PIN_W-1:0] = pin_oe_o;
                IDX_CTL: begin
                    rdata_o[EN_BIT]  = ctrl.en;
                    rdata_o[SRC_BIT] = ctrl.src_deb;
                    rdata_o[1:0]     = ctrl.mode;
                end
                IDX_STAT: rdata_o[PEND_BIT] = irq_pend_o;
                IDX_MASK: rdata_o[PIN_W-1:0] = irq_mask_o;
                default:  rdata_o = '0;
            endcase
        end
    end

    // R9
    stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr_stb));
    // R9
    miss_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wen_i && (addr_i[1:0] != 2'b00)) |=> ($stable(pin_out_o) && $stable(pin_oe_o)
                                              && $stable(irq_mask_o)));
endmodule

// File: tb/test_pin_bank_regs.sv
`timescale 1ns/1ps
module test_pin_bank_regs;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [4:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [W-1:0] raw = '0, deb = '0;
    logic [W-1:0] pout, poe, pmask;
    logic        ien, isrc, ipend, iset = 1'b0;
    logic [1:0]  imode;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // behavioural reference state
    logic [W-1:0] m_out, m_oe, m_mask;
    logic         m_en, m_src, m_pend;
    logic [1:0]   m_mode;

    always #2.5 clk = ~clk;

    pin_bank_regs #(.PIN_W(W)) i_pin_bank_regs (
        .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wen_i(wen), .wdata_i(wdata),
        .rdata_o(rdata), .pin_raw_i(raw), .pin_deb_i(deb), .pin_out_o(pout),
        .pin_oe_o(poe), .irq_en_o(ien), .irq_src_deb_o(isrc), .irq_mode_o(imode),
        .irq_mask_o(pmask), .irq_set_i(iset), .irq_pend_o(ipend)
    );

    function automatic logic [31:0] zx(input logic [W-1:0] v);
        logic [31:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[4:2])
            3'd0: return zx(m_out);
            3'd1: return zx(raw);
            3'd2: return zx(deb);
            3'd3: return zx(m_oe);
            3'd4: return {m_en, 27'd0, m_src, 1'b0, m_mode};
            3'd5: return {m_pend, 31'd0};
            3'd6: return zx(m_mask);
            default: return '0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [4:0] a);
        if (a[1:0] != 2'b00) return "R9";
        case (a[4:2])
            3'd0: return "R2";
            3'd1, 3'd2: return "R7";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_out <= '0; m_oe <= '0; m_mask <= '0;
            m_en <= 0; m_src <= 0; m_pend <= 0; m_mode <= '0;
        end else begin
            if (wen && addr[1:0] == 2'b00) begin
                case (addr[4:2])
                    3'd0: for (int i = 0; i < W; i++) if (m_oe[i]) m_out[i] <= wdata[i];
                    3'd3: m_oe <= wdata[W-1:0];
                    3'd4: begin m_en <= wdata[31]; m_src <= wdata[3]; m_mode <= wdata[1:0]; end
                    3'd6: m_mask <= wdata[W-1:0];
                    default: ;
                endcase
            end
            if (iset) m_pend <= 1'b1;
            else if (wen && addr == 5'h14 && wdata[31]) m_pend <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_ni && !done) begin
            chk("R2 pin_out_o", zx(pout), zx(m_out));
            chk("R3 pin_oe_o", zx(poe), zx(m_oe));
            chk("R4 ctrl fields", {28'd0, ien, isrc, imode}, {28'd0, m_en, m_src, m_mode});
            chk("R5 irq_pend_o", {31'd0, ipend}, {31'd0, m_pend});
            chk("R8 irq_mask_o", zx(pmask), zx(m_mask));
            chk(rd_tag(addr), rdata, m_read(addr));
        end
    end

    task automatic cyc(input logic [4:0] a, input logic we, input logic [31:0] d, input logic s);
        addr = a; wen = we; wdata = d; iset = s;
        @(posedge clk); #1;
        wen = 0; iset = 0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 outputs after reset", {pout, poe}, '0);
        chk("R1 mask/pend after reset", {pmask, ipend, ien, isrc, imode}, '0);
        rst_ni = 1'b1;
        @(posedge clk); #1;
        // R2: value write with no enables changes nothing
        cyc(5'h00, 1, 32'hFFFF_FFFF, 0);
        chk("R2 write with oe=0", zx(pout), 32'h0);
        cyc(5'h0C, 1, 32'h0000_00FF, 0);
        cyc(5'h00, 1, 32'hFFFF_FFFF, 0);
        chk("R2 masked write", zx(pout), 32'h0000_00FF);
        cyc(5'h0C, 1, 32'h0000_F0F0, 0);
        cyc(5'h00, 1, 32'h0, 0);
        chk("R2 partial clear", zx(pout), 32'h0000_000F);
        chk("R3 oe readback", zx(poe), 32'h0000_F0F0);
        // R4: reserved control bits
        cyc(5'h10, 1, 32'hFFFF_FFFF, 0);
        addr = 5'h10; #1;
        chk("R4 ctrl readback", rdata, 32'h8000_000B);
        // R5: set, write-0, write-1
        cyc(5'h14, 0, 0, 1);
        chk("R5 set", {31'd0, ipend}, 32'd1);
        cyc(5'h14, 1, 32'h7FFF_FFFF, 0);
        chk("R5 write 0 keeps", {31'd0, ipend}, 32'd1);
        cyc(5'h14, 1, 32'h8000_0000, 0);
        chk("R5 write 1 clears", {31'd0, ipend}, 32'd0);
        // R6: simultaneous set and clear
        cyc(5'h14, 1, 32'h8000_0000, 1);
        chk("R6 set beats clear", {31'd0, ipend}, 32'd1);
        // R7: input reads, writes ignored
        raw = 16'hA5C3; deb = 16'h3C5A;
        cyc(5'h04, 1, 32'hFFFF_FFFF, 0);
        cyc(5'h08, 1, 32'hFFFF_FFFF, 0);
        addr = 5'h04; #1; chk("R7 raw read", rdata, 32'h0000_A5C3);
        addr = 5'h08; #1; chk("R7 deb read", rdata, 32'h0000_3C5A);
        chk("R7 writes ignored", {pout, poe}, {16'h000F, 16'hF0F0});
        // R8
        cyc(5'h18, 1, 32'hFFFF_1234, 0);
        chk("R8 mask", zx(pmask), 32'h0000_1234);
        // R9
        cyc(5'h1C, 1, 32'hFFFF_FFFF, 0);
        cyc(5'h19, 1, 32'hFFFF_FFFF, 0);
        chk("R9 miss write", {pmask, poe}, {16'h1234, 16'hF0F0});
        addr = 5'h1C; #1; chk("R9 unmapped read", rdata, 32'h0);
        // random mix, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            raw = W'($urandom); deb = W'($urandom);
            cyc(5'($urandom), 1'($urandom), $urandom, ($urandom % 4) == 0);
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule